// File: doc/BRIEF.md
# Immediate Constant Encoder

This block decides whether a 32-bit constant can be carried in the compact 12-bit immediate field used by data-processing instructions as their second operand. It accepts one constant per cycle. Exactly two cycles later it returns a valid flag, an encodable flag, the 12-bit code, and the carry behaviour that a flag-setting logical or test operation would have with that constant. The block also holds the matching combinational decoder, which expands any 12-bit code back to its 32-bit value. A code generator uses the decoder to confirm its choice, and a bench uses it to check round trips.

The design has no state machine. It is a two-stage pipeline: a classify stage, a registered pack stage and a registered output. Stage 1 finds every form the constant fits: plain byte, one of the three repeated-byte layouts, or a byte with its top bit set, shifted up by 1 to 24 places. Stage 2 picks one form by a fixed priority and builds the code. The only pipeline state is the pair of valid bits. A synchronous reset clears both, which drops any request in flight.

Code layout: bits [11:8] are the selector. Selector 0 means the plain byte in code[7:0]. Selector 1 means the byte is repeated in bytes 0 and 2, with bytes 1 and 3 zero. Selector 2 means the byte is repeated in bytes 1 and 3, with bytes 0 and 2 zero. Selector 3 means the byte is repeated in all four bytes. For selector 4 or above, the value is the 8-bit number {1, code[6:0]} rotated right by code[11:7], which is always between 8 and 31.

Top module: `imm_const_encoder`

## Requirements
- R1: A constant below 256, including zero, encodes as selector 0 with code[7:0] equal to the constant.
- R2: A constant of the form 0x00XY00XY (XY nonzero) encodes as selector 1, with code[7:0] = XY.
- R3: A constant of the form 0xXY00XY00 encodes as selector 2, with code[7:0] = XY.
- R4: A constant of the form 0xXYXYXYXY above 255 encodes as selector 3, with code[7:0] = XY.
- R5: A constant above 255 that equals an 8-bit value shifted left, and fits no repeated form, encodes as code[11:7] = 39 − (position of its top set bit) and code[6:0] = the seven bits below that top bit.
- R6: A constant that fits no form gives encodable = 0, code = 0, carry-enable = 0 and carry = 0.
- R7: Carry-enable is 1 exactly for the shifted form of R5, and then carry equals bit 31 of the constant. In every other case carry-enable and carry are 0.
- R8: Forms are chosen by priority: plain byte, then the selector 1, 2 and 3 forms, then the shifted form.
- R9: The result for a request appears exactly two clock edges after the edge that captures it. A request is accepted every cycle, and an idle cycle gives an idle output two cycles later.
- R10: Synchronous active-high reset makes out_valid 0 after the next edge and discards requests in flight.
- R11: The decoder maps every code the encoder produces back to the original 32-bit constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_value | input | 32 | Constant to encode |
| out_valid | output | 1 | Result strobe, two cycles after the request |
| out_enc | output | 1 | Constant is representable |
| out_code | output | 12 | Compact immediate code |
| out_carry_en | output | 1 | Logical flag-setting operations update carry |
| out_carry | output | 1 | Carry value when enabled |
| dec_code | input | 12 | Code to expand (combinational path) |
| dec_value | output | 32 | Expanded 32-bit value |

## Verification
The timing assertions assume that in_valid is a clean binary signal sampled only outside reset, and that reset lasts at least one full cycle. The bench drives every input on the falling edge and holds reset for whole cycles, including one pulse in the middle of a back-to-back burst. The assertions on the code's shape assume nothing about in_value, so the stimulus mixes hand-picked corner constants, shifted random bytes, repeated-byte patterns and unconstrained random words. The decoder port is driven from the registered code, so the round trip never forms a combinational loop.

// File: rtl/imm_enc_pkg.sv
package imm_enc_pkg;
    localparam int IMM_W  = 32;
    localparam int BYTE_W = 8;
    localparam int CODE_W = 12;
    localparam int SEL_W  = 4;
    localparam int ROT_W  = 5;
    localparam int MANT_W = BYTE_W - 1;
    localparam int NPOS   = IMM_W - BYTE_W;   // top-bit positions 8..31

    typedef enum logic [SEL_W-1:0] {
        SEL_BYTE = 4'd0,
        SEL_EVEN = 4'd1,
        SEL_ODD  = 4'd2,
        SEL_ALL  = 4'd3
    } sel_e;

    typedef struct packed {
        logic              is_byte;
        logic              rep_even;
        logic              rep_odd;
        logic              rep_all;
        logic              shifted;
        logic [ROT_W-1:0]  rot;
        logic [MANT_W-1:0] mant;
        logic [BYTE_W-1:0] b_lo;
        logic [BYTE_W-1:0] b_hi;
        logic              msb;
    } cls_t;
endpackage

// File: rtl/imm_classify.sv
module imm_classify
    import imm_enc_pkg::*;
(
    input  logic [IMM_W-1:0] value,
    output cls_t             cls
);
    logic [BYTE_W-1:0] b0, b1, b2, b3;
    logic [NPOS-1:0]   hit;
    logic [MANT_W-1:0] mants [NPOS];

    assign {b3, b2, b1, b0} = value;

    // one candidate per possible top-bit position p = 8..31
    generate
        for (genvar i = 0; i < NPOS; i++) begin : g_pos
            localparam int P  = i + BYTE_W;
            localparam int LO = P - MANT_W;
            assign hit[i]   = value[P]
                            && ((value >> (P + 1)) == '0)
                            && ((value & ((32'h1 << LO) - 32'h1)) == '0);
            assign mants[i] = value[P-1 -: MANT_W];
        end
    endgenerate

    always_comb begin
        cls          = '0;
        cls.is_byte  = (value[IMM_W-1:BYTE_W] == '0);
        cls.rep_even = (b0 == b2) && (b1 == '0) && (b3 == '0);
        cls.rep_odd  = (b1 == b3) && (b0 == '0) && (b2 == '0);
        cls.rep_all  = (b0 == b1) && (b1 == b2) && (b2 == b3);
        cls.b_lo     = b0;
        cls.b_hi     = b1;
        cls.msb      = value[IMM_W-1];
        for (int i = 0; i < NPOS; i++) begin
            if (hit[i]) begin
                cls.shifted = 1'b1;
                cls.rot     = ROT_W'(31 - i);
                cls.mant    = mants[i];
            end
        end
    end

    // R5: at most one top-bit position can match
    always_comb begin
        assert ($onehot0(hit)) else $error("a_r5_unique_position");
    end
endmodule

// File: rtl/imm_pack.sv
module imm_pack
    import imm_enc_pkg::*;
(
    input  cls_t              cls,
    output logic              enc,
    output logic [CODE_W-1:0] code,
    output logic              carry_en,
    output logic              carry
);
    always_comb begin
        enc      = 1'b1;
        code     = '0;
        carry_en = 1'b0;
        carry    = 1'b0;
        if (cls.is_byte)       code = {SEL_BYTE, cls.b_lo};
        else if (cls.rep_even) code = {SEL_EVEN, cls.b_lo};
        else if (cls.rep_odd)  code = {SEL_ODD,  cls.b_hi};
        else if (cls.rep_all)  code = {SEL_ALL,  cls.b_lo};
        else if (cls.shifted) begin
            code     = {cls.rot, cls.mant};
            carry_en = 1'b1;
            carry    = cls.msb;
        end else begin
            enc = 1'b0;
        end
    end

    // R8: the shifted form never overlaps a plain byte
    always_comb begin
        assert (!(cls.shifted && cls.is_byte)) else $error("a_r8_byte_not_shifted");
    end
endmodule

// File: rtl/imm_decode.sv
module imm_decode
    import imm_enc_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output logic [IMM_W-1:0]  value
);
    logic [BYTE_W-1:0]  b;
    logic [SEL_W-1:0]   sel;
    logic [ROT_W-1:0]   rot;
    logic [IMM_W-1:0]   base;
    logic [2*IMM_W-1:0] dbl;

    assign b    = code[BYTE_W-1:0];
    assign sel  = code[CODE_W-1 -: SEL_W];
    assign rot  = code[CODE_W-1 -: ROT_W];
    assign base = {{(IMM_W-BYTE_W){1'b0}}, 1'b1, code[MANT_W-1:0]};
    assign dbl  = {base, base} >> rot;

    always_comb begin
        unique case (sel)
            SEL_BYTE: value = {{(IMM_W-BYTE_W){1'b0}}, b};
            SEL_EVEN: value = {8'h00, b, 8'h00, b};
            SEL_ODD:  value = {b, 8'h00, b, 8'h00};
            SEL_ALL:  value = {b, b, b, b};
            default:  value = dbl[IMM_W-1:0];
        endcase
    end
endmodule

// File: rtl/imm_const_encoder.sv
module imm_const_encoder
    import imm_enc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [IMM_W-1:0]  in_value,
    output logic              out_valid,
    output logic              out_enc,
    output logic [CODE_W-1:0] out_code,
    output logic              out_carry_en,
    output logic              out_carry,
    input  logic [CODE_W-1:0] dec_code,
    output logic [IMM_W-1:0]  dec_value
);
    cls_t              cls_d, s1_cls;
    logic              s1_valid;
    logic              pk_enc, pk_cen, pk_carry;
    logic [CODE_W-1:0] pk_code;

    imm_classify u_classify (.value(in_value), .cls(cls_d));

    always_ff @(posedge clk) begin
        if (rst) s1_valid <= 1'b0;
        else     s1_valid <= in_valid;
        s1_cls <= cls_d;
    end

    imm_pack u_pack (
        .cls      (s1_cls),
        .enc      (pk_enc),
        .code     (pk_code),
        .carry_en (pk_cen),
        .carry    (pk_carry)
    );

    always_ff @(posedge clk) begin
        if (rst) out_valid <= 1'b0;
        else     out_valid <= s1_valid;
        out_enc      <= pk_enc;
        out_code     <= pk_code;
        out_carry_en <= pk_cen;
        out_carry    <= pk_carry;
    end

    imm_decode u_decode (.code(dec_code), .value(dec_value));

    a_r9_latency: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ##2 out_valid);
    a_r9_bubble: assert property (@(posedge clk) disable iff (rst)
        !in_valid |-> ##2 !out_valid);
    a_r10_reset_clears: assert property (@(posedge clk)
        rst |=> !out_valid);
    a_r6_reject_clean: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_enc) |-> (out_code == '0 && !out_carry_en && !out_carry));
    a_r7_carry_only_shifted: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_carry_en) |-> (out_enc && out_code[CODE_W-1 -: 2] != 2'b00));
endmodule

// File: tb/test_imm_const_encoder.sv
module test_imm_const_encoder;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_value = '0;
    logic        out_valid, out_enc, out_carry_en, out_carry;
    logic [11:0] out_code;
    logic [11:0] dec_code = '0;
    logic [31:0] dec_value;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #5 clk = ~clk;

    imm_const_encoder i_imm_const_encoder (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_value(in_value),
        .out_valid(out_valid), .out_enc(out_enc), .out_code(out_code),
        .out_carry_en(out_carry_en), .out_carry(out_carry),
        .dec_code(dec_code), .dec_value(dec_value)
    );

    // expected pipeline: index 0 = captured in stage 1, index 1 = at output
    logic        p_val [2] = '{1'b0, 1'b0};
    logic        p_enc [2];
    logic [11:0] p_code [2];
    logic        p_cen [2];
    logic        p_cy  [2];
    logic [31:0] p_orig [2];
    string       p_tag [2];

    task automatic model(input logic [31:0] v, output logic enc, output logic [11:0] code,
                         output logic cen, output logic cy, output string tag);
        logic [7:0] b [4];
        for (int k = 0; k < 4; k++) b[k] = v[8*k +: 8];
        enc = 1; cen = 0; cy = 0; code = 0;
        if (v < 256) begin code = {4'd0, v[7:0]}; tag = "R1"; end
        else if (b[0] == b[2] && b[1] == 0 && b[3] == 0) begin code = {4'd1, b[0]}; tag = "R2"; end
        else if (b[1] == b[3] && b[0] == 0 && b[2] == 0) begin code = {4'd2, b[1]}; tag = "R3"; end
        else if (b[0] == b[1] && b[1] == b[2] && b[2] == b[3]) begin code = {4'd3, b[0]}; tag = "R4"; end
        else begin
            enc = 0; tag = "R6";
            for (int s = 1; s <= 24; s++) begin
                logic [31:0] m;
                m = v >> s;
                if (!enc && (m << s) == v && m < 256 && m[7]) begin
                    int r;
                    r = 32 - s;
                    enc = 1; cen = 1; cy = v[31];
                    code = {r[4:0], m[6:0]};
                    tag = "R5";
                end
            end
        end
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic step(input bit r, input bit v, input logic [31:0] x);
        @(negedge clk);
        chk(out_valid === p_val[1], p_val[1] ? "R9" : "R10", "out_valid", 32'(out_valid), 32'(p_val[1]));
        if (p_val[1]) begin
            chk(out_enc === p_enc[1], p_tag[1], "out_enc", 32'(out_enc), 32'(p_enc[1]));
            chk(out_code === p_code[1], (p_tag[1] == "R1" && p_orig[1] > 0) ? "R1" : "R8",
                "out_code", 32'(out_code), 32'(p_code[1]));
            chk(out_carry_en === p_cen[1] && out_carry === p_cy[1], "R7",
                "carry", {out_carry_en, out_carry}, {p_cen[1], p_cy[1]});
            if (p_enc[1]) begin
                dec_code = out_code;
                #1;
                chk(dec_value === p_orig[1], "R11", "round trip", dec_value, p_orig[1]);
            end
        end
        rst = r; in_valid = v; in_value = x;
        p_val[1] = r ? 1'b0 : p_val[0];
        p_enc[1] = p_enc[0]; p_code[1] = p_code[0]; p_cen[1] = p_cen[0];
        p_cy[1] = p_cy[0]; p_orig[1] = p_orig[0]; p_tag[1] = p_tag[0];
        p_val[0] = !r && v;
        model(x, p_enc[0], p_code[0], p_cen[0], p_cy[0], p_tag[0]);
        p_orig[0] = x;
    endtask

    logic [31:0] corner [16] = '{
        32'h0000_0000, 32'h0000_00FF, 32'h0000_0100, 32'h00AB_00AB,
        32'hAB00_AB00, 32'hABAB_ABAB, 32'hFF00_0000, 32'h8000_0000,
        32'h0000_0101, 32'h0000_03FC, 32'h1234_5678, 32'hFFFF_FFFF,
        32'h0001_0001, 32'h1FE0_0000, 32'hF000_000F, 32'h0000_01FE
    };

    initial begin
        step(1, 0, 0);
        step(1, 1, 32'h55);
        step(0, 0, 0);
        // R10: reset state gives no output
        @(negedge clk);
        chk(out_valid === 1'b0, "R10", "reset state", 32'(out_valid), 0);
        foreach (corner[k]) step(0, 1, corner[k]);
        for (int k = 0; k < 200; k++) begin
            logic [7:0] byt;
            byt = 8'($urandom);
            step(0, 1, {24'h0, byt} << ($urandom % 25));
            step(0, ($urandom % 4) != 0, {8'h00, byt, 8'h00, byt});
            step(0, 1, {byt, 8'h00, byt, 8'h00});
            step(0, 1, {4{byt}});
            step(0, 1, $urandom);
        end
        // R10: reset in the middle of a burst
        step(0, 1, 32'h0000_0F00);
        step(0, 1, 32'h00C0_00C0);
        step(1, 1, 32'h0003_FC00);
        step(0, 1, 32'h0000_0003);
        for (int k = 0; k < 4; k++) step(0, 0, 0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL R9 watchdog: actual %h expected %h", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule